// File: doc/BRIEF.md
# Oversampled Serial Bit Link

This block connects two nodes through one wired-AND bus line. Each node runs on its own clock, and the two clocks are nominally equal. The transmit half accepts one data bit at a time through a valid/ready handshake. It holds each accepted bit on the line for a slot of eight transmit clock cycles. When it has nothing to send it releases the line high.

Other senders on the same line are modelled by a vector of extra driver inputs. The line carries the AND of every driver, so any driver at 0 pulls the line low.

The receive half runs on its own clock. It passes the line through a two-register synchronizer and stays in a hunting state until it sees the first falling edge. From then on it tracks: a sample counter restarts on every line transition and wraps after eight samples when the line stays steady. The receiver takes the bit at the fourth sample of each period, near the middle of the stable window. This tolerates a one-cycle slip in when a transition is seen and a small drift between the two clocks. Each recovered bit is presented with a one-cycle strobe.

Transmit states are `TX_IDLE` and `TX_SEND`:
- `TX_IDLE` goes to `TX_SEND` on a handshake.
- `TX_SEND` reloads in place on a handshake in the last cycle of a slot.
- `TX_SEND` returns to `TX_IDLE` when no bit is offered at the end of a slot.

Receive states are `RX_HUNT` and `RX_TRACK`:
- `RX_HUNT` goes to `RX_TRACK` on the first synchronized falling edge.
- `RX_TRACK` is never left until reset.

Top module: `osl_link`

## Requirements
- R1: Once a bit is accepted, the transmitter drives it onto its output for exactly 8 consecutive transmit clock cycles, starting one cycle after the accepting edge.
- R2: While in reset, and whenever no bit is being sent, the transmitter drives 1 (line released).
- R3: `bus_line` is the AND of the transmitter output and every bit of `ext_drv`; any input at 0 forces the line to 0.
- R4: The receive logic sees the line only through two registers clocked by `clk_rx`. A falling edge present before receive edge e0 (the first of the seven edges e0 to e6) leaves the receiver idle up to and including edge e5. It then produces `rx_valid`=1 with `rx_bit`=0 after edge e6.
- R5: After reset the receiver asserts no `rx_valid` until the synchronized line has shown a falling edge.
- R6: The sample counter restarts at 0 on every synchronized transition. The bit is captured when the counter holds 3, and `rx_valid` is a single-cycle strobe.
- R7: Without a transition the counter wraps from 7 to 0, so a run of k identical bits yields exactly k recovered bits.
- R8: A stream whose first bit is 0 is recovered bit for bit, in order. This holds when the receive clock period is 0.1% longer than the transmit period, which is within the 0.15% drift bound. After the stream, only idle 1 bits follow.
- R9: `tx_ready` is high in idle and in the last cycle of each slot only. Under continuous valid data, consecutive bits are accepted exactly 8 transmit cycles apart, with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_tx | input | 1 | Transmit clock |
| rst_tx_n | input | 1 | Transmit reset, active low |
| tx_data | input | 1 | Bit offered for transmission |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Transmitter accepts a bit at the next clk_tx edge |
| ext_drv | input | N_EXT | Outputs of other senders on the line (1 = released) |
| bus_line | output | 1 | Wired-AND line value |
| clk_rx | input | 1 | Receive clock |
| rst_rx_n | input | 1 | Receive reset, active low |
| rx_bit | output | 1 | Recovered bit |
| rx_valid | output | 1 | One-cycle strobe marking rx_bit |

## Verification
Two receiver functions can fall in the same receive cycle: realigning the counter on a transition, and wrapping it at the end of a steady run. The receive clock runs 0.1% slower than the transmit clock, so the phase at which transitions land creeps across the counter. Streams with long runs of equal bits followed by a change are used to provoke the case where a transition meets the wrap point. A scoreboard queue filled at each transmit handshake judges the result: any duplicated, lost or misplaced bit shows up as a mismatch or as leftover queue entries.

// File: rtl/osl_pkg.sv
package osl_pkg;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    typedef enum logic {
        RX_HUNT  = 1'b0,
        RX_TRACK = 1'b1
    } rx_state_e;

endpackage

// File: rtl/osl_tx.sv
module osl_tx
    import osl_pkg::*;
#(
    parameter int BIT_REPS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_data,
    input  logic tx_valid,
    output logic tx_ready,
    output logic drv
);

    localparam int CNT_W = (BIT_REPS > 1) ? $clog2(BIT_REPS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_REPS - 1);

    tx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             bit_q, bit_d;
    logic             accept;

    assign accept = tx_valid && tx_ready;

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        bit_d   = bit_q;
        unique case (state_q)
            TX_IDLE: begin
                if (accept) begin
                    state_d = TX_SEND;
                    cnt_d   = '0;
                    bit_d   = tx_data;
                end
            end
            TX_SEND: begin
                if (cnt_q == LAST) begin
                    cnt_d = '0;
                    if (accept) begin
                        bit_d = tx_data;
                    end else begin
                        state_d = TX_IDLE;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
            bit_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            bit_q   <= bit_d;
        end
    end

    // outputs
    always_comb begin
        tx_ready = 1'b0;
        drv      = 1'b1;
        unique case (state_q)
            TX_IDLE: begin
                tx_ready = 1'b1;
                drv      = 1'b1;
            end
            TX_SEND: begin
                tx_ready = (cnt_q == LAST);
                drv      = bit_q;
            end
        endcase
    end

    // R1
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_SEND && cnt_q != '0) |-> $stable(drv));

    // R2
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && !tx_valid) |=> drv);

    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !tx_ready);

endmodule

// File: rtl/osl_sync.sv
module osl_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] sr_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr_q <= RESET_VAL;
                else        sr_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr_q <= {STAGES{RESET_VAL}};
                else        sr_q <= {sr_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = sr_q[STAGES-1];

endmodule

// File: rtl/osl_rx.sv
module osl_rx
    import osl_pkg::*;
#(
    parameter int BIT_REPS   = 8,
    parameter int SAMPLE_AT  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_s,
    output logic rx_bit,
    output logic rx_valid
);

    localparam int CNT_W = (BIT_REPS > 1) ? $clog2(BIT_REPS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_REPS - 1);
    localparam logic [CNT_W-1:0] PICK = CNT_W'(SAMPLE_AT);

    rx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             prev_q;
    logic             edge_seen;
    logic             fall_seen;
    logic             valid_d, bit_d;

    assign edge_seen = (line_s != prev_q);
    assign fall_seen = prev_q && !line_s;

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RX_HUNT: begin
                cnt_d = '0;
                if (fall_seen) begin
                    state_d = RX_TRACK;
                end
            end
            RX_TRACK: begin
                if (edge_seen)          cnt_d = '0;
                else if (cnt_q == LAST) cnt_d = '0;
                else                    cnt_d = cnt_q + 1'b1;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_HUNT;
            cnt_q   <= '0;
            prev_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            prev_q  <= line_s;
        end
    end

    // outputs
    always_comb begin
        valid_d = 1'b0;
        bit_d   = rx_bit;
        unique case (state_q)
            RX_HUNT: begin
                valid_d = 1'b0;
            end
            RX_TRACK: begin
                if (!edge_seen && cnt_q == PICK) begin
                    valid_d = 1'b1;
                    bit_d   = line_s;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_bit   <= 1'b1;
        end else begin
            rx_valid <= valid_d;
            rx_bit   <= bit_d;
        end
    end

    // R5
    hunt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_HUNT) |-> !rx_valid);

    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R6
    realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_TRACK && edge_seen) |=> (cnt_q == '0));

    // R7
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_TRACK && !edge_seen && cnt_q == LAST) |=> (cnt_q == '0));

endmodule

// File: rtl/osl_link.sv
module osl_link #(
    parameter int BIT_REPS    = 8,
    parameter int SAMPLE_AT   = 3,
    parameter int SYNC_STAGES = 2,
    parameter int N_EXT       = 2
) (
    input  logic             clk_tx,
    input  logic             rst_tx_n,
    input  logic             tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    input  logic [N_EXT-1:0] ext_drv,
    output logic             bus_line,
    input  logic             clk_rx,
    input  logic             rst_rx_n,
    output logic             rx_bit,
    output logic             rx_valid
);

    logic tx_drv;
    logic line_s;

    osl_tx #(
        .BIT_REPS (BIT_REPS)
    ) u_tx (
        .clk      (clk_tx),
        .rst_n    (rst_tx_n),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .drv      (tx_drv)
    );

    assign bus_line = tx_drv & (&ext_drv);

    osl_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk   (clk_rx),
        .rst_n (rst_rx_n),
        .din   (bus_line),
        .dout  (line_s)
    );

    osl_rx #(
        .BIT_REPS  (BIT_REPS),
        .SAMPLE_AT (SAMPLE_AT)
    ) u_rx (
        .clk      (clk_rx),
        .rst_n    (rst_rx_n),
        .line_s   (line_s),
        .rx_bit   (rx_bit),
        .rx_valid (rx_valid)
    );

    // R3
    always_comb begin
        if (!tx_drv) begin
            wired_and_chk: assert (!bus_line);
        end
    end

endmodule

// File: tb/test_osl_link.sv
`timescale 1ns/1ps
module test_osl_link;

    localparam real TX_PERIOD_NS = 10.0;
    localparam real RX_PERIOD_NS = 10.01;
    localparam int  N_EXT        = 2;

    logic             clk_tx = 1'b0;
    logic             clk_rx = 1'b0;
    logic             rst_tx_n = 1'b0;
    logic             rst_rx_n = 1'b0;
    logic             tx_data = 1'b1;
    logic             tx_valid = 1'b0;
    logic             tx_ready;
    logic [N_EXT-1:0] ext_drv = '1;
    logic             bus_line;
    logic             rx_bit;
    logic             rx_valid;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;
    bit  mon_en   = 1'b0;
    bit  await_start = 1'b0;
    logic exp_q[$];
    longint tx_cyc = 0;

    always #(TX_PERIOD_NS / 2.0) clk_tx = ~clk_tx;
    always #(RX_PERIOD_NS / 2.0) clk_rx = ~clk_rx;
    always @(posedge clk_tx) tx_cyc <= tx_cyc + 1;

    osl_link #(.N_EXT(N_EXT)) i_osl_link (
        .clk_tx   (clk_tx),
        .rst_tx_n (rst_tx_n),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .ext_drv  (ext_drv),
        .bus_line (bus_line),
        .clk_rx   (clk_rx),
        .rst_rx_n (rst_rx_n),
        .rx_bit   (rx_bit),
        .rx_valid (rx_valid)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: pops expected bits as the receiver produces them.
    always @(negedge clk_rx) begin
        if (mon_en && rx_valid) begin
            if (await_start) begin
                if (rx_bit == 1'b0) begin
                    await_start = 1'b0;
                    check(exp_q.size() > 0 && exp_q[0] == 1'b0, "R8 first bit", rx_bit, 0);
                    if (exp_q.size() > 0) void'(exp_q.pop_front());
                end
            end else if (exp_q.size() > 0) begin
                logic e;
                e = exp_q.pop_front();
                check(rx_bit == e, "R6/R7/R8 recovered bit", rx_bit, e);
            end else begin
                check(rx_bit == 1'b1, "R8 idle bit after stream", rx_bit, 1);
            end
        end
    end

    // Driver: sends n bits of v, most significant first; called at a clk_tx negedge.
    task automatic send_frame(input logic [31:0] v, input int n);
        longint last_acc = 0;
        await_start = 1'b1;
        for (int i = n - 1; i >= 0; i--) begin
            tx_data  = v[i];
            tx_valid = 1'b1;
            while (!tx_ready) @(negedge clk_tx);
            if (i != n - 1)
                check(tx_cyc - last_acc == 8, "R9 back-to-back accept spacing", tx_cyc - last_acc, 8);
            last_acc = tx_cyc;
            exp_q.push_back(v[i]);
            @(posedge clk_tx);
            @(negedge clk_tx);
        end
        tx_valid = 1'b0;
        tx_data  = 1'b1;
    endtask

    task automatic drain();
        for (int k = 0; k < 2000 && exp_q.size() > 0; k++) @(negedge clk_rx);
        for (int k = 0; k < 40; k++) @(negedge clk_rx);
        check(exp_q.size() == 0, "R8 all bits recovered", exp_q.size(), 0);
    endtask

    initial begin
        int seen;
        repeat (4) @(negedge clk_tx);
        // reset state
        check(bus_line == 1'b1, "R2 line released in reset", bus_line, 1);
        check(rx_valid == 1'b0, "R5 no strobe in reset", rx_valid, 0);
        check(tx_ready == 1'b1, "R9 ready when idle", tx_ready, 1);
        // wired-AND with receiver still in reset
        ext_drv = 2'b10;
        #1;
        check(bus_line == 1'b0, "R3 other sender pulls low", bus_line, 0);
        ext_drv = 2'b11;
        #1;
        check(bus_line == 1'b1, "R3 all released", bus_line, 1);

        @(negedge clk_tx); rst_tx_n = 1'b1;
        @(negedge clk_rx); rst_rx_n = 1'b1;

        // R5: idle line, no strobe
        seen = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk_rx);
            if (rx_valid) seen++;
        end
        check(seen == 0, "R5 quiet before first falling edge", seen, 0);

        // R4: latency through synchronizer, falling edge driven before e0
        ext_drv[1] = 1'b0;
        for (int k = 1; k <= 8; k++) begin
            @(posedge clk_rx);
            @(negedge clk_rx);
            if (k < 7)
                check(rx_valid == 1'b0, "R4 no strobe before e6", rx_valid, 0);
            else if (k == 7) begin
                check(rx_valid == 1'b1, "R4 strobe after e6", rx_valid, 1);
                check(rx_bit == 1'b0, "R4 captured bit value", rx_bit, 0);
            end
        end
        ext_drv[1] = 1'b1;
        repeat (30) @(negedge clk_rx);
        mon_en = 1'b1;

        // R1: a lone 0 bit holds the line low for 8 cycles
        @(negedge clk_tx);
        send_frame(32'h0, 1);
        seen = 0;
        while (bus_line == 1'b0 && seen < 20) begin
            seen++;
            @(negedge clk_tx);
        end
        check(seen == 8, "R1 bit slot length", seen, 8);
        drain();

        // R6/R7/R8: streams of varied run lengths
        @(negedge clk_tx); send_frame(32'h5A3C, 16); drain();
        @(negedge clk_tx); send_frame(32'h0F00, 16); drain();
        @(negedge clk_tx); send_frame(32'h0000_0001, 32); drain();
        @(negedge clk_tx); send_frame(32'h7FFF_FFFE, 32); drain();
        @(negedge clk_tx); send_frame(32'h3333_CCCC, 32); drain();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(2_000_000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule